// File: doc/BRIEF.md
# Block Byte Transfer Sequencer

This block paces the data phase of a multi-block card transfer. On one side is a byte-wide card data port with a simple strobe/ready handshake; on the other is a 16-bit word FIFO. When receiving, bytes from the card are gathered two to a word, low byte first, and pushed into the FIFO. When transmitting, words are popped from the FIFO and sent low byte first. A block whose length is odd ends with a half-filled word.

Two length fields set the shape of a transfer: the number of bytes in each block and the number of blocks. Each field holds the wanted value minus one. A live byte counter and a live block counter run down as bytes move. They reload themselves at every block boundary and at the end of the transfer, so the same transfer can be started again without rewriting either field. A start pulse that carries the data-command flag clears the FIFO and latches the direction. A start pulse without that flag cancels any transfer in flight. The end of the last block raises a sticky done flag, which the next start clears.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset both live counters read 1, `busy` and `xfer_done` are 0, and neither card strobe is active.
- R2: Writing the byte-length field with value v makes the byte counter read v+1. Writing the block-count field with value v makes the block counter read v+1 and reloads the byte counter with the current block length.
- R3: A start with `start_data`=1 pulses `fifo_clr` in that cycle, then raises `busy`, latches `start_dir` (1 = receive, 0 = transmit) and clears `xfer_done`. A start with `start_data`=0 drops `busy` and stops all strobes.
- R4: When receiving, the first byte of a word goes to bits 7:0 and the second to bits 15:8. A word is pushed after its second byte, or after a single byte when that byte is the last of its block; in that case bits 15:8 are 0.
- R5: When transmitting, bits 7:0 of the FIFO head word are sent first and bits 15:8 second. The second byte is skipped when the block has no bytes left, and the word is popped after its last byte is sent.
- R6: When receiving, no new word is started while `fifo_level` is greater than `af_level`. A level equal to `af_level` still lets the word start.
- R7: When transmitting, no new word is started while `fifo_level` is 0.
- R8: When the last byte of a block moves, the block counter drops by one and the byte counter reloads the block length.
- R9: When the last byte of the last block moves, the block counter reloads the block count, `busy` falls and `xfer_done` is set.
- R10: At most one byte moves per clock, and only when a strobe and `card_rdy` are both high. While `card_rdy` is low, the counters hold their values.
- R11: `card_rd` and `card_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| len_wr | input | 1 | Write strobe for the byte-length field |
| len_val | input | LEN_W | Block length minus one, in bytes |
| cnt_wr | input | 1 | Write strobe for the block-count field |
| cnt_val | input | LEN_W | Block count minus one |
| start | input | 1 | Command start pulse |
| start_data | input | 1 | 1: data-type command; 0: cancel |
| start_dir | input | 1 | 1: card to FIFO; 0: FIFO to card |
| fifo_level | input | LVL_W | Words currently held in the FIFO |
| af_level | input | AF_W | Almost-full threshold for receive |
| fifo_rdata | input | 16 | FIFO head word |
| fifo_pop | output | 1 | Remove the head word |
| fifo_push | output | 1 | Write `fifo_wdata` into the FIFO |
| fifo_wdata | output | 16 | Packed receive word |
| fifo_clr | output | 1 | Empty the FIFO |
| card_rdy | input | 1 | Card side accepts or supplies a byte this cycle |
| card_rdata | input | 8 | Byte from the card |
| card_rd | output | 1 | Request a byte from the card |
| card_wr | output | 1 | Offer `card_wdata` to the card |
| card_wdata | output | 8 | Byte to the card |
| busy | output | 1 | Transfer in progress |
| xfer_done | output | 1 | Sticky transfer-complete flag |
| byte_left | output | LEN_W+1 | Live byte counter |
| blk_left | output | LEN_W+1 | Live block counter |

## Verification
Directed cases cover a one-byte block, which exposes odd-byte packing and a block boundary at every byte, and a three-byte transmit block, which checks the order of low and high bytes and the early pop. They also cover the almost-full comparison at exactly the threshold and one above it, an empty FIFO during transmit, and a cancel in the middle of a transfer. Random transfers use block lengths of 1 to 12 bytes, which mixes odd and even blocks, and 1 to 3 blocks. During these transfers `card_rdy` toggles at random and the FIFO level is randomised, so stalls land both in the middle of a word and between words. The data that arrives is compared byte for byte with a model of the packing order in the bench. This separates a swapped byte order, a missing skip of the odd byte and a wrong counter reload.

// File: rtl/bxs_pkg.sv
package bxs_pkg;
  typedef logic [7:0]  byte_t;
  typedef logic [15:0] word_t;
  typedef enum logic { DIR_TX = 1'b0, DIR_RX = 1'b1 } xfer_dir_e;

  // Packs two card bytes into a FIFO word, first byte in the low half.
  function automatic word_t pack_word(input byte_t hi, input byte_t lo);
    return {hi, lo};
  endfunction

  // Selects the card byte for the current half of a transmit word.
  function automatic byte_t pick_byte(input word_t w, input logic upper);
    return upper ? w[15:8] : w[7:0];
  endfunction
endpackage

// File: rtl/bxs_counters.sv
module bxs_counters #(
  parameter int LEN_W = 11,
  localparam int CW = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             len_wr,
  input  logic [LEN_W-1:0] len_val,
  input  logic             cnt_wr,
  input  logic [LEN_W-1:0] cnt_val,
  input  logic             byte_done,
  output logic [CW-1:0]    byte_left,
  output logic [CW-1:0]    blk_left,
  output logic             last_byte,
  output logic             xfer_end
);
  function automatic logic [CW-1:0] field_to_count(input logic [LEN_W-1:0] v);
    return {1'b0, v} + CW'(1);
  endfunction

  logic [CW-1:0] blen_q, nblk_q, bytes_q, blks_q;
  logic          last_blk, reg_wr, blk_step;

  assign reg_wr    = len_wr || cnt_wr;
  assign last_byte = (bytes_q == CW'(1));
  assign last_blk  = (blks_q == CW'(1));
  assign blk_step  = byte_done && last_byte && !reg_wr;
  assign xfer_end  = blk_step && last_blk;
  assign byte_left = bytes_q;
  assign blk_left  = blks_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blen_q  <= CW'(1);
      nblk_q  <= CW'(1);
      bytes_q <= CW'(1);
      blks_q  <= CW'(1);
    end else if (reg_wr) begin
      if (len_wr) begin
        blen_q  <= field_to_count(len_val);
        bytes_q <= field_to_count(len_val);
      end
      if (cnt_wr) begin
        nblk_q  <= field_to_count(cnt_val);
        blks_q  <= field_to_count(cnt_val);
        bytes_q <= len_wr ? field_to_count(len_val) : blen_q;
      end
    end else if (byte_done) begin
      if (last_byte) begin
        bytes_q <= blen_q;
        blks_q  <= last_blk ? nblk_q : blks_q - CW'(1);
      end else begin
        bytes_q <= bytes_q - CW'(1);
      end
    end
  end

  // R8
  blk_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_step && !last_blk |=> (blks_q == $past(blks_q) - CW'(1)) && (bytes_q == blen_q));
  // R9
  blk_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> blks_q == nblk_q);
endmodule

// File: rtl/bxs_lane.sv
module bxs_lane
  import bxs_pkg::*;
#(
  parameter int LVL_W = 6,
  parameter int AF_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_data,
  input  logic             start_dir,
  input  logic             xfer_end,
  input  logic             last_byte,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [AF_W-1:0]  af_level,
  input  word_t            fifo_rdata,
  input  logic             card_rdy,
  input  byte_t            card_rdata,
  output logic             busy,
  output logic             card_rd,
  output logic             card_wr,
  output byte_t            card_wdata,
  output logic             fifo_push,
  output word_t            fifo_wdata,
  output logic             fifo_pop,
  output logic             fifo_clr,
  output logic             byte_done
);
  // A new word may open only when the FIFO has room (receive) or data (transmit).
  function automatic logic can_open_word(input xfer_dir_e d, input logic [LVL_W-1:0] lvl,
                                         input logic [AF_W-1:0] af);
    return (d == DIR_RX) ? (lvl <= LVL_W'(af)) : (lvl != '0);
  endfunction

  logic      busy_q, half_q, open_ok, card_req, word_close;
  xfer_dir_e dir_q;
  byte_t     lo_q;

  always_comb begin
    open_ok    = can_open_word(dir_q, fifo_level, af_level);
    card_req   = busy_q && !start && (half_q || open_ok);
    card_rd    = card_req && (dir_q == DIR_RX);
    card_wr    = card_req && (dir_q == DIR_TX);
    byte_done  = card_req && card_rdy;
    word_close = byte_done && (half_q || last_byte);
    fifo_push  = word_close && (dir_q == DIR_RX);
    fifo_pop   = word_close && (dir_q == DIR_TX);
    fifo_wdata = half_q ? pack_word(card_rdata, lo_q) : pack_word(8'h00, card_rdata);
    card_wdata = pick_byte(fifo_rdata, half_q);
    fifo_clr   = start && start_data;
    busy       = busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      half_q <= 1'b0;
      dir_q  <= DIR_RX;
      lo_q   <= '0;
    end else if (start) begin
      busy_q <= start_data;
      half_q <= 1'b0;
      if (start_data) dir_q <= xfer_dir_e'(start_dir);
    end else begin
      if (xfer_end) busy_q <= 1'b0;
      if (byte_done) begin
        half_q <= !half_q && !last_byte;
        if (!half_q) lo_q <= card_rdata;
      end
    end
  end

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({card_rd, card_wr}));
  // R6
  rx_full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && dir_q == DIR_RX && !half_q && (fifo_level > LVL_W'(af_level)) |-> !card_rd);
  // R7
  tx_empty_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && dir_q == DIR_TX && !half_q && fifo_level == '0 |-> !card_wr);
  // R4
  push_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> card_rd && card_rdy);
  // R5
  pop_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> card_wr && card_rdy);
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import bxs_pkg::*;
#(
  parameter int LEN_W      = 11,
  parameter int FIFO_DEPTH = 32,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1),
  localparam int AF_W  = $clog2(FIFO_DEPTH),
  localparam int CW    = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             len_wr,
  input  logic [LEN_W-1:0] len_val,
  input  logic             cnt_wr,
  input  logic [LEN_W-1:0] cnt_val,
  input  logic             start,
  input  logic             start_data,
  input  logic             start_dir,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [AF_W-1:0]  af_level,
  input  logic [15:0]      fifo_rdata,
  output logic             fifo_pop,
  output logic             fifo_push,
  output logic [15:0]      fifo_wdata,
  output logic             fifo_clr,
  input  logic             card_rdy,
  input  logic [7:0]       card_rdata,
  output logic             card_rd,
  output logic             card_wr,
  output logic [7:0]       card_wdata,
  output logic             busy,
  output logic             xfer_done,
  output logic [CW-1:0]    byte_left,
  output logic [CW-1:0]    blk_left
);
  logic byte_done, last_byte, xfer_end, done_q;

  bxs_counters #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .len_wr(len_wr), .len_val(len_val),
    .cnt_wr(cnt_wr), .cnt_val(cnt_val), .byte_done(byte_done),
    .byte_left(byte_left), .blk_left(blk_left),
    .last_byte(last_byte), .xfer_end(xfer_end)
  );

  bxs_lane #(.LVL_W(LVL_W), .AF_W(AF_W)) u_lane (
    .clk(clk), .rst_n(rst_n), .start(start), .start_data(start_data),
    .start_dir(start_dir), .xfer_end(xfer_end), .last_byte(last_byte),
    .fifo_level(fifo_level), .af_level(af_level), .fifo_rdata(fifo_rdata),
    .card_rdy(card_rdy), .card_rdata(card_rdata), .busy(busy),
    .card_rd(card_rd), .card_wr(card_wr), .card_wdata(card_wdata),
    .fifo_push(fifo_push), .fifo_wdata(fifo_wdata), .fifo_pop(fifo_pop),
    .fifo_clr(fifo_clr), .byte_done(byte_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done_q <= 1'b0;
    else if (start)    done_q <= 1'b0;
    else if (xfer_end) done_q <= 1'b1;
  end
  assign xfer_done = done_q;

  // R9
  end_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end && !start |=> !busy && xfer_done);
  // R3
  data_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && start_data |=> busy && !xfer_done);
  // R3
  cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !start_data |=> !busy && !card_rd && !card_wr);
  // R10
  rdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !card_rdy && !len_wr && !cnt_wr |=> $stable(byte_left) && $stable(blk_left));
endmodule

// File: tb/blk_xfer_seq_tb.sv
module blk_xfer_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 11;
  localparam int CW = LEN_W + 1;

  logic clk = 0, rst_n = 0;
  logic len_wr = 0, cnt_wr = 0, start = 0, start_data = 0, start_dir = 0;
  logic [LEN_W-1:0] len_val = '0, cnt_val = '0;
  logic [5:0] fifo_level = '0;
  logic [4:0] af_level = '0;
  logic [15:0] fifo_rdata = '0, fifo_wdata;
  logic fifo_pop, fifo_push, fifo_clr, card_rdy = 0, card_rd, card_wr, busy, xfer_done;
  logic [7:0] card_rdata = '0, card_wdata;
  logic [CW-1:0] byte_left, blk_left;

  int total = 0, bad = 0;
  logic [15:0] txq [64];
  logic [15:0] got_w [64];
  logic [7:0]  got_b [128];

  blk_xfer_seq u_dut (
    .clk(clk), .rst_n(rst_n), .len_wr(len_wr), .len_val(len_val), .cnt_wr(cnt_wr),
    .cnt_val(cnt_val), .start(start), .start_data(start_data), .start_dir(start_dir),
    .fifo_level(fifo_level), .af_level(af_level), .fifo_rdata(fifo_rdata),
    .fifo_pop(fifo_pop), .fifo_push(fifo_push), .fifo_wdata(fifo_wdata),
    .fifo_clr(fifo_clr), .card_rdy(card_rdy), .card_rdata(card_rdata),
    .card_rd(card_rd), .card_wr(card_wr), .card_wdata(card_wdata),
    .busy(busy), .xfer_done(xfer_done), .byte_left(byte_left), .blk_left(blk_left)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cbyte(input int k);
    return 8'((k * 29 + 11) ^ (k >> 3));
  endfunction

  task automatic wr_regs(input int lv, input int cv);
    @(negedge clk); len_wr = 1; len_val = LEN_W'(lv);
    @(negedge clk); len_wr = 0; cnt_wr = 1; cnt_val = LEN_W'(cv);
    @(negedge clk); cnt_wr = 0;
  endtask

  task automatic go(input bit dir);
    @(negedge clk); start = 1; start_data = 1; start_dir = dir;
    @(negedge clk); start = 0;
  endtask

  task automatic run_random(input bit dir);
    int L = 1 + int'($urandom % 12);
    int N = 1 + int'($urandom % 3);
    int af = int'($urandom % 32);
    int wpb = (L + 1) / 2;
    int nw = N * wpb;
    int c_idx = 0, tx_idx = 0, nb = 0, nwd = 0, cyc = 0, mism = 0;
    for (int i = 0; i < nw; i++) txq[i] = 16'($urandom);
    af_level = 5'(af);
    wr_regs(L - 1, N - 1);
    go(dir);
    forever begin
      @(negedge clk);
      card_rdy = ($urandom % 3) != 0;
      if (dir) fifo_level = 6'($urandom % (af + 4));
      else fifo_level = (($urandom % 5) == 0) ? 6'd0 : 6'((nw - tx_idx) > 32 ? 32 : nw - tx_idx);
      fifo_rdata = (tx_idx < nw) ? txq[tx_idx] : 16'h0;
      card_rdata = cbyte(c_idx);
      #1;
      if (!busy || cyc > 3000) break;
      cyc++;
      if (card_rd && card_rdy) c_idx++;
      if (card_wr && card_rdy && nb < 128) begin got_b[nb] = card_wdata; nb++; end
      if (fifo_push && nwd < 64) begin got_w[nwd] = fifo_wdata; nwd++; end
      if (fifo_pop) tx_idx++;
    end
    chk(cyc <= 3000, "R9 transfer finishes", cyc, 3000);
    if (dir) begin
      // R4: low-first packing, odd last byte alone with zero upper half
      chk(nwd == nw, "R4 rx word count", nwd, nw);
      for (int b = 0; b < N; b++)
        for (int j = 0; j < L; j += 2) begin
          int k = b * L + j;
          logic [15:0] e = {(j + 1 < L) ? cbyte(k + 1) : 8'h00, cbyte(k)};
          int wi = b * wpb + j / 2;
          if (wi < nwd && got_w[wi] != e) mism++;
        end
      chk(mism == 0, "R4 rx word contents", mism, 0);
    end else begin
      // R5: low byte then high byte, high skipped at odd block end
      chk(nb == N * L, "R5 tx byte count", nb, N * L);
      chk(tx_idx == nw, "R5 tx pops", tx_idx, nw);
      for (int b = 0; b < N; b++)
        for (int j = 0; j < L; j++) begin
          logic [15:0] w = txq[b * wpb + j / 2];
          logic [7:0] e = (j % 2) ? w[15:8] : w[7:0];
          if (b * L + j < nb && got_b[b * L + j] != e) mism++;
        end
      chk(mism == 0, "R5 tx byte order", mism, 0);
    end
    // R8 R9: counters reloaded, done set
    chk(byte_left == CW'(L), "R8 byte reload", int'(byte_left), L);
    chk(blk_left == CW'(N), "R9 block reload", int'(blk_left), N);
    chk(xfer_done == 1'b1, "R9 done flag", int'(xfer_done), 1);
    card_rdy = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1
    chk(byte_left == 1 && blk_left == 1, "R1 reset counters", int'({byte_left, blk_left}), 12'h001 << 12 | 1);
    chk(!busy && !xfer_done && !card_rd && !card_wr, "R1 reset flags",
        int'({busy, xfer_done, card_rd, card_wr}), 0);

    // R2
    @(negedge clk); len_wr = 1; len_val = 11'd5;
    @(negedge clk); len_wr = 0; #1;
    chk(byte_left == 6, "R2 length readback", int'(byte_left), 6);
    cnt_wr = 1; cnt_val = 11'd2;
    @(negedge clk); cnt_wr = 0; #1;
    chk(blk_left == 3 && byte_left == 6, "R2 count readback", int'(blk_left), 3);

    // Directed receive: one-byte blocks, two blocks
    wr_regs(0, 1);
    af_level = 5'd10; fifo_level = 6'd11; card_rdy = 1;
    @(negedge clk); start = 1; start_data = 1; start_dir = 1; #1;
    chk(fifo_clr == 1'b1, "R3 fifo clear pulse", int'(fifo_clr), 1);
    @(negedge clk); start = 0; #1;
    chk(busy == 1'b1 && xfer_done == 1'b0, "R3 busy after start", int'(busy), 1);
    chk(fifo_clr == 1'b0, "R3 clear is one cycle", int'(fifo_clr), 0);
    chk(card_rd == 1'b0, "R6 stall above threshold", int'(card_rd), 0);
    @(negedge clk); fifo_level = 6'd10; card_rdy = 0; card_rdata = 8'h3C; #1;
    chk(card_rd == 1'b1, "R6 start at threshold", int'(card_rd), 1);
    chk(fifo_push == 1'b0, "R10 no move without ready", int'(fifo_push), 0);
    @(negedge clk); #1;
    chk(byte_left == 1 && blk_left == 2, "R10 counters held", int'(blk_left), 2);
    card_rdy = 1; #1;
    chk(fifo_push && fifo_wdata == 16'h003C, "R4 odd byte word", int'(fifo_wdata), 16'h003C);
    @(negedge clk); card_rdata = 8'hC3; #1;
    chk(blk_left == 1 && byte_left == 1 && busy, "R8 block step", int'(blk_left), 1);
    chk(fifo_push && fifo_wdata == 16'h00C3, "R4 second block word", int'(fifo_wdata), 16'h00C3);
    @(negedge clk); card_rdy = 0; #1;
    chk(!busy && xfer_done && blk_left == 2, "R9 end of transfer", int'({busy, xfer_done}), 1);

    // Directed transmit: three-byte block
    wr_regs(2, 0);
    fifo_level = 6'd0; card_rdy = 1;
    go(1'b0); #1;
    chk(card_wr == 1'b0 && card_rd == 1'b0, "R7 stall on empty", int'(card_wr), 0);
    @(negedge clk); fifo_level = 6'd2; fifo_rdata = 16'hA55A; #1;
    chk(card_wr && card_wdata == 8'h5A && !fifo_pop, "R5 low byte first", int'(card_wdata), 8'h5A);
    @(negedge clk); #1;
    chk(card_wr && card_wdata == 8'hA5 && fifo_pop, "R5 high byte then pop", int'(card_wdata), 8'hA5);
    @(negedge clk); fifo_level = 6'd1; fifo_rdata = 16'h0077; #1;
    chk(card_wdata == 8'h77 && fifo_pop, "R5 odd last byte pops", int'(card_wdata), 8'h77);
    @(negedge clk); card_rdy = 0; #1;
    chk(!busy && xfer_done, "R9 tx end", int'(busy), 0);

    // Cancel mid transfer
    wr_regs(7, 3);
    fifo_level = 6'd0; card_rdy = 1; af_level = 5'd31;
    go(1'b1);
    @(negedge clk); #1;
    @(negedge clk); start = 1; start_data = 0;
    @(negedge clk); start = 0; #1;
    chk(!busy && !card_rd && !card_wr, "R3 cancel stops transfer", int'(busy), 0);
    card_rdy = 0;

    // Random transfers, both directions (R4 R5 R8 R9 R10 R11 via assertions and data)
    for (int t = 0; t < 12; t++) run_random(t[0]);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule